// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This block carries out maintenance operations on the status bits of a write-back data cache. Each cache line has a valid bit and a dirty bit, and the status array holding them sits outside the block. The sequencer drives a single line index into that array. It reads back the indexed line's valid and dirty bits combinationally. It writes new values through a one-cycle write strobe. When a valid dirty line has to reach memory, it raises a writeback request that carries the line's set and way. It then waits on a valid/ready handshake before it moves on.

Software asks for one of seven operations. Three are whole-cache walks: clean, clean with invalidate, and invalidate without writeback. Three act on a single line named by set and way: clean, clean with invalidate, and invalidate. The seventh is test-clean. It writes back only the first dirty line it meets in walk order and reports through a flag whether it found one. Software issues test-clean again and again until the flag reads zero. A walk treats the set index as the fast-moving counter: it covers every set of way 0, then every set of way 1, and so on.

Lines that need no action cost one cycle each and generate no memory traffic. A busy output covers the whole operation. A one-cycle done pulse marks its end.

Top module: `cmaint_seq`

## Requirements
- R1: During and directly after reset, busy, done, wb_valid, st_we and tc_found are all 0.
- R2: A command is taken when cmd_valid is high while busy is low and cmd_op is one of 0..6. Busy is 1 from the next cycle. Op code 7, and any command presented while busy, are ignored and change no line.
- R3: Whole-cache operations visit lines in the order set 0..SETS-1 of way 0, then the same sets of way 1, and so on up to the last way, so writebacks appear in that order.
- R4: Op 0 (clean all) writes back every line that is valid and dirty exactly once, and clears its dirty bit while leaving it valid. Lines that are not both valid and dirty produce no writeback and keep their bits. While wb_valid is high, the indexed line is valid and dirty.
- R5: Op 1 (clean and invalidate all) writes back exactly the lines that op 0 would. Afterwards every line is invalid and clean. Maintenance never sets a dirty bit and never makes an invalid line valid.
- R6: Op 2 (invalidate all) issues no writeback and leaves every line invalid and clean.
- R7: Op 3 (test-clean) writes back only the first valid dirty line in walk order, clears its dirty bit, keeps it valid, and sets tc_found to 1. If no such line exists, it issues no writeback and tc_found is 0. Repeating the op until tc_found is 0 leaves no dirty line.
- R8: Op 4 (clean line), op 5 (clean and invalidate line) and op 6 (invalidate line) act only on the line selected by cmd_set and cmd_way, with the same per-line effect as ops 0, 1 and 2. All other lines are untouched.
- R9: Once raised, wb_valid stays high with idx_set and idx_way unchanged until a cycle in which wb_ready is high.
- R10: Busy stays high until the operation's final line is handled. Done is a one-cycle pulse in the first cycle with busy low. No status write or writeback happens while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code 0..6, 7 reserved |
| cmd_set | input | SET_W | Set of the target line for single-line ops |
| cmd_way | input | WAY_W | Way of the target line for single-line ops |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at completion |
| tc_found | output | 1 | Last test-clean found and wrote back a dirty line |
| idx_set | output | SET_W | Set of the line currently addressed |
| idx_way | output | WAY_W | Way of the line currently addressed |
| st_valid | input | 1 | Valid bit of the addressed line |
| st_dirty | input | 1 | Dirty bit of the addressed line |
| st_we | output | 1 | Write strobe for the addressed line's status |
| st_wr_valid | output | 1 | Valid bit to write |
| st_wr_dirty | output | 1 | Dirty bit to write |
| wb_valid | output | 1 | Writeback request for the addressed line |
| wb_ready | input | 1 | Memory side accepts the writeback |

## Verification
Several properties are checked on every cycle. The writeback handshake must hold its request and index while stalled. A writeback may only target a valid dirty line, and it must clear that line's dirty bit. Status writes must never set dirty or create a valid line. Nothing may be written or requested while idle. Done must follow the fall of busy, and a legal command taken while idle must raise busy. Other behaviour can only be shown by the bench's scenarios, which compare the writeback sequence and the final array against a model: whether the walk covers every line in set-then-way order, whether test-clean stops at the first dirty line, whether a single-line op leaves other lines alone, and whether reserved or overlapping commands are dropped.

// File: rtl/cmaint_pkg.sv
package cmaint_pkg;

    typedef enum logic [2:0] {
        OP_CLEAN_ALL     = 3'd0,
        OP_CLEAN_INV_ALL = 3'd1,
        OP_INV_ALL       = 3'd2,
        OP_TEST_CLEAN    = 3'd3,
        OP_LINE_CLEAN    = 3'd4,
        OP_LINE_CLN_INV  = 3'd5,
        OP_LINE_INV      = 3'd6,
        OP_RSVD          = 3'd7
    } maint_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SCAN = 2'd1,
        SQ_WB   = 2'd2
    } seq_state_e;

    // per-line action: write back, drop (clear valid)
    typedef struct packed {
        logic wb;
        logic drop;
    } line_act_t;

    function automatic logic op_legal(maint_op_e op);
        return op != OP_RSVD;
    endfunction

    function automatic logic op_writes_back(maint_op_e op);
        return op inside {OP_CLEAN_ALL, OP_CLEAN_INV_ALL, OP_TEST_CLEAN,
                          OP_LINE_CLEAN, OP_LINE_CLN_INV};
    endfunction

    function automatic logic op_drops(maint_op_e op);
        return op inside {OP_CLEAN_INV_ALL, OP_INV_ALL, OP_LINE_CLN_INV, OP_LINE_INV};
    endfunction

    function automatic logic op_single(maint_op_e op);
        return op inside {OP_LINE_CLEAN, OP_LINE_CLN_INV, OP_LINE_INV};
    endfunction

endpackage

// File: rtl/cmaint_cursor.sv
module cmaint_cursor #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int SET_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SET_W-1:0] load_set,
    input  logic [WAY_W-1:0] load_way,
    input  logic             step,
    output logic [SET_W-1:0] cur_set,
    output logic [WAY_W-1:0] cur_way,
    output logic             last_all
);
    localparam logic [SET_W-1:0] SET_MAX = SET_W'(SETS - 1);
    localparam logic [WAY_W-1:0] WAY_MAX = WAY_W'(WAYS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_set <= '0;
            cur_way <= '0;
        end else if (load) begin
            cur_set <= load_set;
            cur_way <= load_way;
        end else if (step) begin
            if (cur_set == SET_MAX) begin
                cur_set <= '0;
                cur_way <= cur_way + WAY_W'(1);
            end else begin
                cur_set <= cur_set + SET_W'(1);
            end
        end
    end

    assign last_all = (cur_set == SET_MAX) && (cur_way == WAY_MAX);

endmodule

// File: rtl/cmaint_line_decide.sv
module cmaint_line_decide
    import cmaint_pkg::*;
(
    input  maint_op_e op,
    input  logic      line_valid,
    input  logic      line_dirty,
    output line_act_t act
);
    always_comb begin
        act.wb   = line_valid && line_dirty && op_writes_back(op);
        act.drop = line_valid && op_drops(op);
    end
endmodule

// File: rtl/cmaint_seq.sv
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    output logic             busy,
    output logic             done,
    output logic             tc_found,
    output logic [SET_W-1:0] idx_set,
    output logic [WAY_W-1:0] idx_way,
    input  logic             st_valid,
    input  logic             st_dirty,
    output logic             st_we,
    output logic             st_wr_valid,
    output logic             st_wr_dirty,
    output logic             wb_valid,
    input  logic             wb_ready
);
    seq_state_e state_q, state_d;
    maint_op_e  op_q;
    maint_op_e  op_in;
    line_act_t  act;
    logic       found_q, done_q;
    logic       accept, step, finish, mark_found, last_all, end_here;

    assign op_in  = maint_op_e'(cmd_op);
    assign accept = (state_q == SQ_IDLE) && cmd_valid && op_legal(op_in);

    cmaint_cursor #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) cursor_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_set (op_single(op_in) ? cmd_set : '0),
        .load_way (op_single(op_in) ? cmd_way : '0),
        .step     (step),
        .cur_set  (idx_set),
        .cur_way  (idx_way),
        .last_all (last_all)
    );

    cmaint_line_decide decide_i (
        .op         (op_q),
        .line_valid (st_valid),
        .line_dirty (st_dirty),
        .act        (act)
    );

    assign end_here = op_single(op_q) || last_all;

    always_comb begin
        state_d     = state_q;
        st_we       = 1'b0;
        st_wr_valid = 1'b0;
        st_wr_dirty = 1'b0;
        wb_valid    = 1'b0;
        step        = 1'b0;
        finish      = 1'b0;
        mark_found  = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (accept) state_d = SQ_SCAN;
            end
            SQ_SCAN: begin
                if (act.wb) begin
                    state_d    = SQ_WB;
                    mark_found = (op_q == OP_TEST_CLEAN);
                end else begin
                    if (act.drop) begin
                        st_we = 1'b1;
                    end
                    if (end_here) finish = 1'b1;
                    else          step   = 1'b1;
                end
            end
            SQ_WB: begin
                wb_valid = 1'b1;
                if (wb_ready) begin
                    st_we       = 1'b1;
                    st_wr_valid = !act.drop;
                    if (end_here || op_q == OP_TEST_CLEAN) finish = 1'b1;
                    else begin
                        step    = 1'b1;
                        state_d = SQ_SCAN;
                    end
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (finish) state_d = SQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_CLEAN_ALL;
            found_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                op_q <= op_in;
                if (op_in == OP_TEST_CLEAN) found_q <= 1'b0;
            end else if (mark_found) begin
                found_q <= 1'b1;
            end
        end
    end

    assign busy     = (state_q != SQ_IDLE);
    assign done     = done_q;
    assign tc_found = found_q;

endmodule

// File: rtl/cmaint_seq_chk.sv
module cmaint_seq_chk #(
    parameter int SET_W = 3,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             busy,
    input logic             done,
    input logic [SET_W-1:0] idx_set,
    input logic [WAY_W-1:0] idx_way,
    input logic             st_valid,
    input logic             st_dirty,
    input logic             st_we,
    input logic             st_wr_valid,
    input logic             st_wr_dirty,
    input logic             wb_valid,
    input logic             wb_ready
);
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(idx_set) && $stable(idx_way)); // R9
    AST_WB_DIRTY_LINE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> st_valid && st_dirty); // R4
    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_ready |-> st_we && !st_wr_dirty); // R4
    AST_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
        st_we |-> !st_wr_dirty && !(st_wr_valid && !st_valid)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !st_we && !wb_valid); // R10
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy)); // R10
    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        !busy && cmd_valid && cmd_op != 3'd7 |=> busy); // R2
endmodule

bind cmaint_seq cmaint_seq_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .idx_set(idx_set), .idx_way(idx_way),
    .st_valid(st_valid), .st_dirty(st_dirty), .st_we(st_we),
    .st_wr_valid(st_wr_valid), .st_wr_dirty(st_wr_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready)
);

// File: tb/cmaint_seq_tb_top.sv
module cmaint_seq_tb_top;
    localparam int  SETS   = 8;
    localparam int  WAYS   = 4;
    localparam int  LINES  = SETS * WAYS;
    localparam int  SET_W  = $clog2(SETS);
    localparam int  WAY_W  = $clog2(WAYS);
    localparam time CLK_PERIOD = 10ns;

    // vector: {op[2:0], set[3:0], way[3:0], seed[3:0], ready_mode}
    localparam int NVEC = 11;
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {3'd0, 4'd0, 4'd0, 4'd1,  1'b0},
        {3'd0, 4'd0, 4'd0, 4'd2,  1'b1},
        {3'd1, 4'd0, 4'd0, 4'd3,  1'b1},
        {3'd2, 4'd0, 4'd0, 4'd4,  1'b0},
        {3'd3, 4'd0, 4'd0, 4'd5,  1'b1},
        {3'd3, 4'd0, 4'd0, 4'd0,  1'b0},
        {3'd4, 4'd3, 4'd2, 4'd15, 1'b1},
        {3'd5, 4'd7, 4'd1, 4'd15, 1'b0},
        {3'd6, 4'd0, 4'd3, 4'd15, 1'b0},
        {3'd1, 4'd0, 4'd0, 4'd0,  1'b1},
        {3'd4, 4'd5, 4'd0, 4'd0,  1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [SET_W-1:0] cmd_set = '0;
    logic [WAY_W-1:0] cmd_way = '0;
    logic busy, done, tc_found, st_we, st_wr_valid, st_wr_dirty, wb_valid;
    logic [SET_W-1:0] idx_set;
    logic [WAY_W-1:0] idx_way;
    logic st_valid, st_dirty;
    logic wb_ready = 1'b1;

    logic mv [0:LINES-1];
    logic md [0:LINES-1];
    logic xv [0:LINES-1];
    logic xd [0:LINES-1];
    int   wb_log [0:LINES-1];
    int   xlog [0:LINES-1];
    int   wb_n, xn;
    logic xfound;
    int   checks = 0, fails = 0, cyc = 0;
    logic rmode = 1'b0, force_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmaint_seq #(.SETS(SETS), .WAYS(WAYS)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_set(cmd_set), .cmd_way(cmd_way), .busy(busy), .done(done),
        .tc_found(tc_found), .idx_set(idx_set), .idx_way(idx_way),
        .st_valid(st_valid), .st_dirty(st_dirty), .st_we(st_we),
        .st_wr_valid(st_wr_valid), .st_wr_dirty(st_wr_dirty),
        .wb_valid(wb_valid), .wb_ready(wb_ready)
    );

    assign st_valid = mv[int'(idx_way) * SETS + int'(idx_set)];
    assign st_dirty = md[int'(idx_way) * SETS + int'(idx_set)];

    // status array model and writeback log
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (st_we) begin
            mv[int'(idx_way) * SETS + int'(idx_set)] <= st_wr_valid;
            md[int'(idx_way) * SETS + int'(idx_set)] <= st_wr_dirty;
        end
        if (wb_valid && wb_ready && wb_n < LINES) begin
            wb_log[wb_n] <= int'(idx_way) * SETS + int'(idx_set);
            wb_n <= wb_n + 1;
        end
    end

    always @(negedge clk) begin
        wb_ready <= force_low ? 1'b0 : (rmode ? (cyc % 3 == 0) : 1'b1);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic preload(input int seed);
        for (int i = 0; i < LINES; i++) begin
            int h;
            h = (i * 7 + seed * 13) % 5;
            if (seed == 0)       begin mv[i] = 1'b1; md[i] = 1'b0; end
            else if (seed == 15) begin mv[i] = 1'b1; md[i] = 1'b1; end
            else begin mv[i] = (h != 0); md[i] = (h >= 3); end
        end
    endtask

    // expected result from the requirements
    task automatic calc_expected(input int op, input int s, input int w);
        bit stop;
        stop = 0;
        xn = 0;
        xfound = 1'b0;
        for (int i = 0; i < LINES; i++) begin xv[i] = mv[i]; xd[i] = md[i]; end
        for (int wy = 0; wy < WAYS; wy++) begin
            for (int st = 0; st < SETS; st++) begin
                int i;
                bit sel;
                i = wy * SETS + st;
                sel = (op >= 4) ? (st == s && wy == w) : 1'b1;
                if (sel && !stop) begin
                    if (op == 3) begin
                        if (xv[i] && xd[i]) begin
                            xlog[xn] = i; xn++; xd[i] = 1'b0; xfound = 1'b1; stop = 1;
                        end
                    end else begin
                        if ((op == 0 || op == 1 || op == 4 || op == 5) && xv[i] && xd[i]) begin
                            xlog[xn] = i; xn++; xd[i] = 1'b0;
                        end
                        if ((op == 1 || op == 2 || op == 5 || op == 6) && xv[i]) begin
                            xv[i] = 1'b0; xd[i] = 1'b0;
                        end
                    end
                end
            end
        end
    endtask

    task automatic issue(input int op, input int s, input int w);
        @(negedge clk);
        wb_n = 0;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_set = SET_W'(s); cmd_way = WAY_W'(w);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        int k;
        k = 0;
        while (!done && k < 5000) begin @(negedge clk); k++; end
        ok = done;
    endtask

    task automatic compare(input string req);
        int bad;
        bad = 0;
        chk(wb_n == xn, req, wb_n, xn);
        for (int k = 0; k < xn && k < wb_n; k++)
            chk(wb_log[k] == xlog[k], req, wb_log[k], xlog[k]);
        for (int i = 0; i < LINES; i++)
            if (mv[i] !== xv[i] || md[i] !== xd[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ok;
        string rq;
        preload(0);
        wb_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(!busy && !done && !wb_valid && !st_we && !tc_found, "R1 in reset",
            {busy, done, wb_valid, st_we, tc_found}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !wb_valid && !st_we && !tc_found, "R1 after reset",
            {busy, done, wb_valid, st_we, tc_found}, 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            int op, s, w, seed;
            op = int'(VEC[v][15:13]); s = int'(VEC[v][12:9]);
            w = int'(VEC[v][8:5]); seed = int'(VEC[v][4:1]);
            rmode = VEC[v][0];
            @(negedge clk);
            preload(seed);
            calc_expected(op, s, w);
            case (op)
                0: rq = "R4 clean all";
                1: rq = "R5 clean+inv all";
                2: rq = "R6 inv all";
                3: rq = "R7 test-clean";
                default: rq = "R8 line op";
            endcase
            issue(op, s, w);
            chk(busy == 1'b1, "R10 busy after accept", busy, 1);
            wait_done(ok);
            chk(ok, "R10 done pulse", ok, 1);
            @(negedge clk);
            chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);
            compare(rq);
            if (op == 3) chk(tc_found == xfound, "R7 found flag", tc_found, xfound);
        end
        rmode = 1'b0;

        // R3 walk order: all lines dirty, clean-all logs lines in order
        preload(15);
        issue(0, 0, 0);
        wait_done(ok);
        @(negedge clk);
        chk(wb_n == LINES, "R3 count", wb_n, LINES);
        for (int k = 0; k < LINES; k++)
            if (wb_log[k] != k) chk(0, "R3 order", wb_log[k], k);
        chk(wb_log[SETS] == SETS, "R3 way advance after set wrap", wb_log[SETS], SETS);

        // R2 reserved op ignored
        preload(15);
        issue(7, 0, 0);
        chk(!busy, "R2 reserved op", busy, 0);
        repeat (3) @(negedge clk);
        begin
            int dn;
            dn = 0;
            for (int i = 0; i < LINES; i++) if (md[i] && mv[i]) dn++;
            chk(dn == LINES && wb_n == 0, "R2 reserved op no change", dn, LINES);
        end

        // R2 command while busy ignored
        preload(2);
        calc_expected(0, 0, 0);
        rmode = 1'b1;
        issue(0, 0, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd2;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(ok);
        repeat (3) @(negedge clk);
        chk(!busy, "R2 no second run", busy, 0);
        compare("R2 busy command ignored");
        rmode = 1'b0;

        // R7 test-clean loop
        preload(1);
        begin
            int nd, it, left;
            nd = 0; it = 0; left = 0;
            for (int i = 0; i < LINES; i++) if (mv[i] && md[i]) nd++;
            for (int r = 0; r < 40; r++) begin
                issue(3, 0, 0);
                wait_done(ok);
                @(negedge clk);
                it++;
                if (!tc_found) break;
            end
            for (int i = 0; i < LINES; i++) if (md[i]) left++;
            chk(it == nd + 1, "R7 loop iterations", it, nd + 1);
            chk(left == 0, "R7 no dirty left", left, 0);
        end

        // R9 stall holds request
        preload(15);
        force_low = 1'b1;
        @(negedge clk);
        issue(0, 0, 0);
        begin
            int k, held;
            logic [SET_W-1:0] s0;
            logic [WAY_W-1:0] w0;
            k = 0;
            while (!wb_valid && k < 50) begin @(negedge clk); k++; end
            s0 = idx_set; w0 = idx_way;
            held = 1;
            for (int r = 0; r < 20; r++) begin
                @(negedge clk);
                if (!wb_valid || idx_set != s0 || idx_way != w0) held = 0;
            end
            chk(held == 1 && wb_n == 0, "R9 stall hold", held, 1);
        end
        force_low = 1'b0;
        wait_done(ok);
        @(negedge clk);
        chk(wb_n == LINES, "R9 all written after release", wb_n, LINES);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule